// File: doc/BRIEF.md
# MSI-X Interrupt Request Processor

This block turns interrupt requests for a set of message-signalled vectors into PCIe Memory Write requests. A request names a vector and sets that vector's pending bit. Each vector also has an entry in a small internal table. The entry holds a 64-bit message address, split into lower and upper dwords, a 32-bit message data word and a control word. Bit 0 of the control word masks the vector. The table is loaded through a one-cycle register write port.

While no message is in flight, the block picks the lowest-numbered vector that is pending and not masked. It copies that vector's table entry and sends a single-dword Memory Write to a TX stream, one dword per beat: the header comes first and the data dword last. The header is three dwords long when the upper address is zero and four dwords long otherwise. A masked vector stays pending and is sent as soon as software unmasks it. The pending bits can be read at any time as 64-bit qwords.

Top module: `msix_irq_proc`

## Requirements
- R1: After reset, no vector is pending, every table entry has zero address and zero data, every entry is masked, and `tx_valid` is low.
- R2: A request with `irq_vec` < NUM_VEC sets that vector's pending bit. A request with a larger number changes nothing. A request for a vector that is already pending is merged, so a vector that is requested twice while pending produces one message.
- R3: `pba_data` shows qword `pba_qidx`. Qword k sits at byte offset 8·k of the pending array, and its bit j is the pending bit of vector 64·k+j. Bits for vectors at or above NUM_VEC read 0, and so do qwords beyond index (NUM_VEC-1) div 64.
- R4: A vector whose control word has bit 0 set sends no message and stays pending. Control bits 31:1 have no effect. Table write selects are: 0 for lower address, 1 for upper address, 2 for data and 3 for control.
- R5: Clearing the mask bit of a vector that is still pending causes its message to be sent with no new request.
- R6: A message with a zero upper address is four beats long: 32'h4000_0001, then {REQ_ID, 8'h00, 8'hFF}, then {addr_lo[31:2], 2'b00}, then the data. With a nonzero upper address it is five beats long: 32'h6000_0001, then {REQ_ID, 8'h00, 8'hFF}, then the upper address, then {addr_lo[31:2], 2'b00}, then the data.
- R7: `tx_sop` marks the first beat and `tx_eop` marks the last. A beat is held unchanged while `tx_valid` is high and `tx_ready` is low.
- R8: A vector's pending bit stays set while its message is in flight. The bit clears at the clock edge where the last beat is accepted (`tx_valid` and `tx_ready` both high). A request for the same vector in that same cycle leaves the bit set.
- R9: Only one message is in flight at a time. The next message begins with the lowest-numbered vector that is pending and unmasked. `tx_valid` is low for at least one cycle after each accepted last beat.
- R10: A message uses the table contents captured when it begins. Table writes made during a message affect only later messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VEC_W | Requested vector number |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_vec | input | VEC_W | Table entry to write |
| cfg_wr_sel | input | 2 | Word select: 0 lower address, 1 upper address, 2 data, 3 control |
| cfg_wr_data | input | 32 | Table write value |
| pba_qidx | input | PBA_QW | Pending-array qword index (byte offset divided by 8) |
| pba_data | output | 64 | Pending qword read value |
| tx_valid | output | 1 | TX beat valid |
| tx_ready | input | 1 | TX sink ready |
| tx_sop | output | 1 | First beat of a message |
| tx_eop | output | 1 | Last beat of a message |
| tx_data | output | 32 | TX dword |

## Verification
The assertions check on every cycle that a beat is held stable under backpressure and that every first beat carries a Memory Write format with a length of one. They also check that a vector in flight stays pending until its last beat is accepted, and then clears unless it was requested again in that same cycle. The gap after each message and the rule that out-of-range requests are ignored are checked on every cycle as well. The bench's scenarios are needed to show the rest:
- the order in which several pending vectors are serviced;
- that duplicate requests merge into one message;
- that masked vectors wait until they are unmasked;
- that the header grows to four dwords when the upper address is nonzero;
- that a table write made during a message does not change that message.

// File: rtl/msix_pkg.sv
package msix_pkg;

  localparam int BEAT_W = 3;

  typedef struct packed {
    logic [29:0] lo_w;
    logic [31:0] hi;
    logic [31:0] data;
  } msg_t;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } tbl_sel_e;

  function automatic logic needs_4dw(input logic [31:0] hi);
    return hi != 32'h0;
  endfunction

  function automatic logic [BEAT_W-1:0] last_beat(input logic four);
    return four ? BEAT_W'(4) : BEAT_W'(3);
  endfunction

  function automatic logic [31:0] hdr_dw0(input logic four);
    logic [2:0] fmt;
    fmt = four ? 3'b011 : 3'b010;
    return {fmt, 5'b00000, 14'h0, 10'd1};
  endfunction

  function automatic logic [31:0] hdr_dw1(input logic [15:0] rid);
    return {rid, 8'h00, 4'hF, 4'hF};
  endfunction

  function automatic logic [31:0] beat_dword(input msg_t m, input logic [BEAT_W-1:0] beat,
                                             input logic [15:0] rid);
    logic four;
    four = needs_4dw(m.hi);
    case (beat)
      BEAT_W'(0): return hdr_dw0(four);
      BEAT_W'(1): return hdr_dw1(rid);
      BEAT_W'(2): return four ? m.hi : {m.lo_w, 2'b00};
      BEAT_W'(3): return four ? {m.lo_w, 2'b00} : m.data;
      default:    return m.data;
    endcase
  endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 72,
  parameter int VEC_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VEC_W-1:0]   wr_vec,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  input  logic [VEC_W-1:0]   rd_vec,
  output msg_t               rd_msg,
  output logic [NUM_VEC-1:0] mask_vec
);

  logic [29:0] lo_q   [NUM_VEC];
  logic [31:0] hi_q   [NUM_VEC];
  logic [31:0] data_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_vec) < NUM_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]   <= '0;
        hi_q[i]   <= '0;
        data_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_ok) begin
      case (tbl_sel_e'(wr_sel))
        SEL_LO:   lo_q[wr_vec]   <= wr_data[31:2];
        SEL_HI:   hi_q[wr_vec]   <= wr_data;
        SEL_DATA: data_q[wr_vec] <= wr_data;
        default:  mask_q[wr_vec] <= wr_data[0];
      endcase
    end
  end

  logic [1:0] unused_lo_bits;
  assign unused_lo_bits = (tbl_sel_e'(wr_sel) == SEL_LO) ? wr_data[1:0] : 2'b00;

  always_comb begin
    rd_msg.lo_w = lo_q[rd_vec];
    rd_msg.hi   = hi_q[rd_vec];
    rd_msg.data = data_q[rd_vec];
  end

  assign mask_vec = mask_q;

  // R1: right after reset, every vector is masked
  p_reset_masked_r1: assert property (@(posedge clk)
    $past(!rst_n) && rst_n |-> &mask_q);

endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array #(
  parameter int NUM_VEC = 72,
  parameter int VEC_W   = 7,
  parameter int PBA_QW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VEC_W-1:0]   set_vec,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_vec,
  input  logic [NUM_VEC-1:0] mask_vec,
  output logic [NUM_VEC-1:0] pend_vec,
  output logic               elig_any,
  output logic [VEC_W-1:0]   elig_idx,
  input  logic [PBA_QW-1:0]  rd_qidx,
  output logic [63:0]        rd_qword
);

  localparam int NQW  = (NUM_VEC - 1) / 64 + 1;
  localparam int PADW = NQW * 64;

  logic [NUM_VEC-1:0] pend_q, pend_d, elig;
  logic set_ok;

  assign set_ok = set_en && (int'(set_vec) < NUM_VEC);

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_vec] = 1'b0;
    if (set_ok) pend_d[set_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_vec = pend_q;
  assign elig     = pend_q & ~mask_vec;

  always_comb begin
    elig_any = 1'b0;
    elig_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        elig_any = 1'b1;
        elig_idx = VEC_W'(i);
      end
    end
  end

  logic [PADW-1:0] pad;
  always_comb begin
    pad = '0;
    pad[NUM_VEC-1:0] = pend_q;
  end

  logic [63:0] qw [NQW];
  for (genvar k = 0; k < NQW; k++) begin : g_qw
    assign qw[k] = pad[k*64 +: 64];
  end

  always_comb begin
    rd_qword = '0;
    for (int k = 0; k < NQW; k++) begin
      if (int'(rd_qidx) == k) rd_qword = qw[k];
    end
  end

  // R2: an out-of-range request leaves the pending bits unchanged
  p_range_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && (int'(set_vec) >= NUM_VEC) && !clr_en |=> pend_q == $past(pend_q));

endmodule

// File: rtl/msix_tx_serializer.sv
module msix_tx_serializer
  import msix_pkg::*;
#(
  parameter int          VEC_W  = 7,
  parameter logic [15:0] REQ_ID = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] start_vec,
  input  msg_t             start_msg,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [31:0]      tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             busy,
  output logic             done,
  output logic [VEC_W-1:0] cur_vec
);

  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  msg_t              msg_q;
  logic [VEC_W-1:0]  vec_q;
  logic              four, accept, at_last;

  assign four    = needs_4dw(msg_q.hi);
  assign at_last = beat_q == last_beat(four);
  assign accept  = busy_q && tx_ready;
  assign done    = accept && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      msg_q  <= '0;
      vec_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      msg_q  <= start_msg;
      vec_q  <= start_vec;
    end else if (accept) begin
      if (at_last) busy_q <= 1'b0;
      else         beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = beat_dword(msg_q, beat_q, REQ_ID);
  assign tx_sop   = busy_q && (beat_q == '0);
  assign tx_eop   = busy_q && at_last;
  assign busy     = busy_q;
  assign cur_vec  = vec_q;

  // R7: a stalled beat is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  // R6: every first beat is a Memory Write with a length of one dword
  p_sop_fmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data[31:30] == 2'b01 && tx_data[28:24] == 5'b0 && tx_data[9:0] == 10'd1);

  // R9: a new message never begins while one is in flight
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !done |=> tx_valid && $stable(cur_vec));

endmodule

// File: rtl/msix_irq_proc.sv
module msix_irq_proc
  import msix_pkg::*;
#(
  parameter int          NUM_VEC = 72,
  parameter int          VEC_W   = $clog2(NUM_VEC),
  parameter int          PBA_QW  = 3,
  parameter logic [15:0] REQ_ID  = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_valid,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             cfg_wr_en,
  input  logic [VEC_W-1:0] cfg_wr_vec,
  input  logic [1:0]       cfg_wr_sel,
  input  logic [31:0]      cfg_wr_data,
  input  logic [PBA_QW-1:0] pba_qidx,
  output logic [63:0]      pba_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic [31:0]      tx_data
);

  logic [NUM_VEC-1:0] mask_vec, pend_vec;
  logic               elig_any, busy, done, start;
  logic [VEC_W-1:0]   elig_idx, cur_vec;
  msg_t               sel_msg;

  assign start = elig_any && !busy;

  msix_vec_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_vec(cfg_wr_vec), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rd_vec(elig_idx), .rd_msg(sel_msg), .mask_vec(mask_vec)
  );

  msix_pend_array #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .PBA_QW(PBA_QW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(irq_valid), .set_vec(irq_vec),
    .clr_en(done), .clr_vec(cur_vec),
    .mask_vec(mask_vec), .pend_vec(pend_vec),
    .elig_any(elig_any), .elig_idx(elig_idx),
    .rd_qidx(pba_qidx), .rd_qword(pba_data)
  );

  msix_tx_serializer #(.VEC_W(VEC_W), .REQ_ID(REQ_ID)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_vec(elig_idx), .start_msg(sel_msg),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop),
    .busy(busy), .done(done), .cur_vec(cur_vec)
  );

  // R8: a vector stays pending while its message is in flight
  p_inflight_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pend_vec[cur_vec]);

  // R8: the pending bit drops once the last beat is accepted, unless it was requested again
  p_clear_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(irq_valid && irq_vec == cur_vec) |=> !pend_vec[$past(cur_vec)]);

  // R8: a request in the accept cycle keeps the bit set
  p_rerequest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && irq_valid && irq_vec == cur_vec |=> pend_vec[$past(cur_vec)]);

  // R9: one idle cycle follows every completed message
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tx_valid);

endmodule

// File: tb/sim_msix_irq_proc.sv
`timescale 1ns/1ps
module sim_msix_irq_proc;
  localparam int          NV  = 72;
  localparam int          VW  = 7;
  localparam int          QW  = 3;
  localparam logic [15:0] RID = 16'h0100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, irq_valid, cfg_wr_en, tx_ready, tx_valid, tx_sop, tx_eop;
  logic [VW-1:0] irq_vec, cfg_wr_vec;
  logic [1:0] cfg_wr_sel;
  logic [31:0] cfg_wr_data, tx_data;
  logic [QW-1:0] pba_qidx;
  logic [63:0] pba_data;

  msix_irq_proc #(.NUM_VEC(NV), .VEC_W(VW), .PBA_QW(QW), .REQ_ID(RID)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_vec(cfg_wr_vec), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .pba_qidx(pba_qidx), .pba_data(pba_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_data(tx_data)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit          m_pend [NV];
  logic [31:0] m_lo [NV], m_hi [NV], m_dat [NV], m_ctl [NV];
  bit          m_busy;
  int          m_beat, m_vec;
  logic [31:0] m_q [$];
  logic [31:0] seen_eop [$];
  logic [31:0] seen_sop [$];
  bit          ready_mode = 0;
  logic [7:0]  lfsr = 8'h5A;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NV; i++) begin
      m_pend[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_dat[i] = 0; m_ctl[i] = 32'h1;
    end
    m_busy = 0; m_beat = 0; m_vec = 0; m_q = {};
  endtask

  task automatic model_step();
    int sel;
    sel = -1;
    if (m_busy) begin
      if (tx_ready) begin
        if (m_beat == m_q.size() - 1) begin
          m_pend[m_vec] = 0;
          m_busy = 0;
        end else m_beat++;
      end
    end else begin
      for (int i = NV - 1; i >= 0; i--)
        if (m_pend[i] && !m_ctl[i][0]) sel = i;
      if (sel >= 0) begin
        m_q = {};
        m_q.push_back((m_hi[sel] != 0) ? 32'h6000_0001 : 32'h4000_0001);
        m_q.push_back({RID, 8'h00, 8'hFF});
        if (m_hi[sel] != 0) m_q.push_back(m_hi[sel]);
        m_q.push_back({m_lo[sel][31:2], 2'b00});
        m_q.push_back(m_dat[sel]);
        m_busy = 1; m_beat = 0; m_vec = sel;
      end
    end
    if (irq_valid && int'(irq_vec) < NV) m_pend[irq_vec] = 1;
    if (cfg_wr_en && int'(cfg_wr_vec) < NV) begin
      case (cfg_wr_sel)
        2'd0: m_lo[cfg_wr_vec] = cfg_wr_data;
        2'd1: m_hi[cfg_wr_vec] = cfg_wr_data;
        2'd2: m_dat[cfg_wr_vec] = cfg_wr_data;
        default: m_ctl[cfg_wr_vec] = cfg_wr_data;
      endcase
    end
  endtask

  task automatic compare();
    logic [63:0] exp_q;
    chk("R9 tx_valid", 64'(tx_valid), 64'(m_busy));
    if (m_busy) begin
      chk("R6 tx_data", 64'(tx_data), 64'(m_q[m_beat]));
      chk("R7 tx_sop", 64'(tx_sop), 64'(m_beat == 0));
      chk("R7 tx_eop", 64'(tx_eop), 64'(m_beat == m_q.size() - 1));
    end
    exp_q = '0;
    for (int j = 0; j < 64; j++) begin
      int v;
      v = int'(pba_qidx) * 64 + j;
      if (v < NV) exp_q[j] = m_pend[v];
    end
    chk("R3 pba_data", pba_data, exp_q);
  endtask

  task automatic tick();
    if (tx_valid && tx_ready && tx_sop) seen_sop.push_back(tx_data);
    if (tx_valid && tx_ready && tx_eop) seen_eop.push_back(tx_data);
    model_step();
    @(posedge clk);
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = ready_mode ? lfsr[0] : 1'b1;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic req(input int v);
    irq_valid = 1; irq_vec = VW'(v);
    tick();
    irq_valid = 0;
  endtask

  task automatic cfg(input int v, input int sel, input logic [31:0] d);
    cfg_wr_en = 1; cfg_wr_vec = VW'(v); cfg_wr_sel = 2'(sel); cfg_wr_data = d;
    tick();
    cfg_wr_en = 0;
  endtask

  task automatic prog(input int v, input logic [31:0] hi, input bit unmask);
    cfg(v, 0, 32'h0000_1003 + 32'(v) * 16);
    cfg(v, 1, hi);
    cfg(v, 2, 32'hD000_0000 + 32'(v));
    if (unmask) cfg(v, 3, 32'h0);
  endtask

  function automatic logic [31:0] dat(input int v);
    return 32'hD000_0000 + 32'(v);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    int n3;
    rst_n = 0; irq_valid = 0; irq_vec = '0; cfg_wr_en = 0; cfg_wr_vec = '0;
    cfg_wr_sel = '0; cfg_wr_data = '0; pba_qidx = '0; tx_ready = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();
    // R1: reset state
    chk("R1 tx_valid", 64'(tx_valid), 64'(0));
    chk("R1 pba q0", pba_data, 64'h0);

    // R1/R4: vector 5 is masked after reset, so it only goes pending
    req(5);
    run(8);
    chk("R4 masked stays pending", 64'(pba_data[5]), 64'(1));
    chk("R1 no message while masked", 64'(seen_eop.size()), 64'(0));

    prog(5, 32'h0, 0);
    prog(66, 32'h0000_0002, 0);
    req(66);
    pba_qidx = 3'd1; run(2);
    chk("R3 qword1 holds vector 66", pba_data, 64'h4);
    pba_qidx = 3'd2; run(1);
    chk("R3 qword beyond last", pba_data, 64'h0);
    pba_qidx = 3'd0; run(1);
    chk("R3 qword0 holds vector 5", pba_data, 64'h20);

    // R5/R4: unmask with upper control bits set
    cfg(5, 3, 32'hFFFF_FFFE);
    run(12);
    chk("R5 message after unmask", 64'(seen_eop.size()), 64'(1));
    chk("R4 upper control bits ignored", 64'(seen_eop[0]), 64'(dat(5)));
    chk("R6 3DW first dword", 64'(seen_sop[0]), 64'h4000_0001);
    chk("R8 pending cleared", 64'(pba_data[5]), 64'(0));

    // R6: four-dword header for nonzero upper address
    cfg(66, 3, 32'h0);
    run(12);
    chk("R6 4DW first dword", 64'(seen_sop[1]), 64'h6000_0001);
    chk("R6 4DW data", 64'(seen_eop[1]), 64'(dat(66)));

    // R9/R2: priority, merge and out-of-range
    prog(7, 32'h0, 1); prog(1, 32'h0, 1); prog(3, 32'h0, 1); prog(70, 32'h1, 1);
    seen_eop = {};
    req(7); tick();
    req(70); req(100); req(7); req(1); req(3);
    run(40);
    chk("R2 merged and ignored count", 64'(seen_eop.size()), 64'(4));
    if (seen_eop.size() == 4) begin
      chk("R9 order 0", 64'(seen_eop[0]), 64'(dat(7)));
      chk("R9 order 1", 64'(seen_eop[1]), 64'(dat(1)));
      chk("R9 order 2", 64'(seen_eop[2]), 64'(dat(3)));
      chk("R9 order 3", 64'(seen_eop[3]), 64'(dat(70)));
    end
    pba_qidx = 3'd1; run(1);
    chk("R2 vector 100 not pending", pba_data, 64'h0);
    pba_qidx = 3'd0;

    // R7: backpressure
    ready_mode = 1; seen_eop = {};
    req(5); req(66);
    run(80);
    ready_mode = 0; run(2);
    chk("R7 both delivered under stall", 64'(seen_eop.size()), 64'(2));

    // R10: table write during a message
    seen_eop = {};
    req(5);
    for (int i = 0; i < 50 && !(tx_valid && tx_sop); i++) tick();
    cfg(5, 2, 32'h1234_5678);
    run(15);
    chk("R10 old data used", 64'(seen_eop[seen_eop.size()-1]), 64'(dat(5)));
    req(5); run(15);
    chk("R10 new data later", 64'(seen_eop[seen_eop.size()-1]), 64'h1234_5678);

    // R8: request in the same cycle as the final accept
    seen_eop = {};
    req(3);
    for (int i = 0; i < 50 && !(tx_valid && tx_eop); i++) tick();
    req(3);
    chk("R8 re-request keeps pending", 64'(pba_data[3]), 64'(1));
    run(20);
    n3 = 0;
    foreach (seen_eop[i]) if (seen_eop[i] == dat(3)) n3++;
    chk("R8 second message sent", 64'(n3), 64'(2));

    summary();
    $finish;
  end
endmodule